// File: doc/BRIEF.md
# Fetch Stage Control Sequencer

This block decides, once per clock, what the instruction fetch stage of a pipelined processor does. It can fetch, block, squash, or wait for an instruction-cache miss to be filled. It watches redirect and squash requests from commit and decode, a flag from commit saying the reorder buffer is still being drained, stall requests from four downstream stages, and the miss, fill-done and fault responses of the fetch datapath. It owns the fetch program counter. It drives the fetch-enable strobe for the datapath, the repair and update commands for the branch predictor, and a cancel for an outstanding cache request.

Incoming events are weighed in a fixed order. A commit squash comes first. Reorder-buffer draining comes next, then a decode squash, then the OR of the stall requests. Only after these does the stage look at its own state. A cycle that leaves the blocked state is spent idle. A cycle that leaves the squashing state fetches at once. Three saturating counters record fetch, squash and blocked cycles.

Top module: `fetch_ctl`

## Requirements
- R1: Reset puts the stage in Idle (state code 0) with `pc` = RESET_PC, `next_pc` = RESET_PC + INST_BYTES and all three counters at zero. An Idle stage fetches like Running. State codes are Idle 0, Running 1, Squashing 2, Blocked 3, MissWait 4, MissFilled 5.
- R2: `cmt_squash` overrides every other input. In that cycle `fetch_en` is 0. At the next edge `pc` takes `cmt_target`, `next_pc` becomes `cmt_target` + INST_BYTES, and the state becomes Squashing.
- R3: A commit squash drives `fix_valid` = 1 together with `fix_mispred`, `fix_taken`, `fix_seq` and `fix_target` copied from the commit inputs. A decode squash with no commit squash and no drain drives the same outputs from the decode inputs. This holds even when the decode squash does not redirect.
- R4: `upd_valid` is 1, with `upd_seq` = `cmt_seq`, in any cycle where `cmt_seq` is nonzero and `cmt_squash` is 0.
- R5: While `cmt_rob_busy` is 1 and there is no commit squash, the state becomes Squashing and `fetch_en` is 0. Decode squashes and stalls are ignored in that cycle, so `fix_valid` is 0 and the state does not become Blocked.
- R6: A decode squash loads `pc` from `dec_target` and enters Squashing only when the current state is not Squashing. Otherwise evaluation continues with the stall check, so the PC follows the normal fetch path.
- R7: When no squash or drain applies and any of `dec_stall`, `ren_stall`, `exe_stall`, `cmt_stall` is 1, the state becomes Blocked and `fetch_en` is 0, whatever the current state.
- R8: In Blocked with no stall, no held fault and no squash, the state returns to Running and `fetch_en` stays 0 for that cycle.
- R9: In Squashing with no squash, drain or stall, `fetch_en` is 1 in that same cycle.
- R10: A fetch with `ic_miss` = 1 enters MissWait and holds `pc`. MissWait never fetches. `ic_done` moves MissWait to MissFilled only when no higher-priority event occurs in that cycle. MissFilled fetches and ignores `ic_miss`.
- R11: `ic_cancel` is 1 exactly when a commit squash or a decode redirect arrives while the state is MissWait.
- R12: A fetch with `fetch_fault` = 1 enters Blocked and stays there through stall-free cycles. Only a commit squash, reorder-buffer drain or decode redirect releases it.
- R13: `run_cnt` counts cycles with `fetch_en` = 1. `squash_cnt` counts commit-squash, drain and decode-redirect cycles. `blocked_cnt` counts stall cycles and cycles spent in Blocked. Each counter saturates at its all-ones value.
- R14: A fetch with no fault and no miss, or any fetch from MissFilled, loads `pc` with `dp_next_pc` and enters Running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmt_squash | input | 1 | Commit requests a squash and redirect |
| cmt_mispred | input | 1 | Commit squash is a branch mispredict |
| cmt_taken | input | 1 | Resolved direction of the commit branch |
| cmt_target | input | PCW | Commit redirect target |
| cmt_seq | input | SEQW | Sequence number completed at commit (0 = none) |
| cmt_rob_busy | input | 1 | Reorder buffer still draining a squash |
| cmt_stall | input | 1 | Stall from commit |
| dec_squash | input | 1 | Decode requests a squash and redirect |
| dec_mispred | input | 1 | Decode squash is a branch mispredict |
| dec_taken | input | 1 | Resolved direction of the decode branch |
| dec_target | input | PCW | Decode redirect target |
| dec_seq | input | SEQW | Sequence number of the decode squash |
| dec_stall | input | 1 | Stall from decode |
| ren_stall | input | 1 | Stall from rename |
| exe_stall | input | 1 | Stall from execute |
| ic_miss | input | 1 | Cache miss on this cycle's fetch |
| ic_done | input | 1 | Outstanding miss has been filled (pulse) |
| fetch_fault | input | 1 | Translation or memory fault on this cycle's fetch |
| dp_next_pc | input | PCW | PC after this cycle's fetch group, from the datapath |
| fetch_en | output | 1 | Datapath may fetch this cycle |
| state | output | 3 | Current state code |
| pc | output | PCW | Fetch program counter |
| next_pc | output | PCW | pc + INST_BYTES |
| fix_valid | output | 1 | Predictor repair or squash command |
| fix_mispred | output | 1 | Command is a mispredict repair |
| fix_taken | output | 1 | Corrected direction |
| fix_seq | output | SEQW | Sequence number for the command |
| fix_target | output | PCW | Corrected target |
| upd_valid | output | 1 | Predictor update command |
| upd_seq | output | SEQW | Sequence number to update |
| ic_cancel | output | 1 | Cancel the outstanding cache request |
| run_cnt | output | CNTW | Fetch cycle counter |
| squash_cnt | output | CNTW | Squash cycle counter |
| blocked_cnt | output | CNTW | Blocked cycle counter |

## Verification
The hardest situations to reach are the ones that need two conditions lined up. One is a redirect landing while a miss is outstanding. The other is a fault being held in Blocked while every stall is low. The directed sequences build these on purpose. For the first, a lone miss is followed by a commit squash. For the second, a faulting fetch is followed by quiet cycles and then a decode redirect. The seeded random phase keeps each squash and fault source rare and the miss source frequent, so MissWait and MissFilled come up often. It also runs long enough that the narrow counters used by the bench saturate.

// File: rtl/fetch_ctl.sv
module fetch_ctl #(
  parameter int PCW        = 32,
  parameter int SEQW       = 16,
  parameter int CNTW       = 32,
  parameter int INST_BYTES = 4,
  parameter logic [PCW-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmt_squash,
  input  logic            cmt_mispred,
  input  logic            cmt_taken,
  input  logic [PCW-1:0]  cmt_target,
  input  logic [SEQW-1:0] cmt_seq,
  input  logic            cmt_rob_busy,
  input  logic            cmt_stall,
  input  logic            dec_squash,
  input  logic            dec_mispred,
  input  logic            dec_taken,
  input  logic [PCW-1:0]  dec_target,
  input  logic [SEQW-1:0] dec_seq,
  input  logic            dec_stall,
  input  logic            ren_stall,
  input  logic            exe_stall,
  input  logic            ic_miss,
  input  logic            ic_done,
  input  logic            fetch_fault,
  input  logic [PCW-1:0]  dp_next_pc,
  output logic            fetch_en,
  output logic [2:0]      state,
  output logic [PCW-1:0]  pc,
  output logic [PCW-1:0]  next_pc,
  output logic            fix_valid,
  output logic            fix_mispred,
  output logic            fix_taken,
  output logic [SEQW-1:0] fix_seq,
  output logic [PCW-1:0]  fix_target,
  output logic            upd_valid,
  output logic [SEQW-1:0] upd_seq,
  output logic            ic_cancel,
  output logic [CNTW-1:0] run_cnt,
  output logic [CNTW-1:0] squash_cnt,
  output logic [CNTW-1:0] blocked_cnt
);

  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_RUN    = 3'd1,
    S_SQUASH = 3'd2,
    S_BLOCK  = 3'd3,
    S_MWAIT  = 3'd4,
    S_MFILL  = 3'd5
  } st_t;

  localparam logic [PCW-1:0]  STEP = PCW'(INST_BYTES);
  localparam logic [CNTW-1:0] CMAX = '1;

  st_t            st_q, st_d;
  logic [PCW-1:0] pc_q, pc_d;
  logic           hold_q, hold_d;
  logic           inc_run, inc_sq, inc_blk;
  logic           stall_any, dec_fix, dec_redirect;

  assign stall_any    = dec_stall | ren_stall | exe_stall | cmt_stall;
  assign dec_fix      = !cmt_squash && !cmt_rob_busy && dec_squash;
  assign dec_redirect = dec_fix && st_q != S_SQUASH;

  assign fix_valid   = cmt_squash | dec_fix;
  assign fix_mispred = cmt_squash ? cmt_mispred : dec_fix & dec_mispred;
  assign fix_taken   = cmt_squash ? cmt_taken   : dec_fix & dec_taken;
  assign fix_seq     = cmt_squash ? cmt_seq     : (dec_fix ? dec_seq : '0);
  assign fix_target  = cmt_squash ? cmt_target  : (dec_fix ? dec_target : '0);

  assign upd_valid = !cmt_squash && cmt_seq != '0;
  assign upd_seq   = upd_valid ? cmt_seq : '0;

  assign ic_cancel = (cmt_squash || dec_redirect) && st_q == S_MWAIT;

  always_comb begin
    st_d     = st_q;
    pc_d     = pc_q;
    hold_d   = hold_q;
    fetch_en = 1'b0;
    inc_run  = 1'b0;
    inc_sq   = 1'b0;
    inc_blk  = 1'b0;
    if (cmt_squash) begin
      pc_d   = cmt_target;
      st_d   = S_SQUASH;
      hold_d = 1'b0;
      inc_sq = 1'b1;
    end else if (cmt_rob_busy) begin
      st_d   = S_SQUASH;
      hold_d = 1'b0;
      inc_sq = 1'b1;
    end else if (dec_redirect) begin
      pc_d   = dec_target;
      st_d   = S_SQUASH;
      hold_d = 1'b0;
      inc_sq = 1'b1;
    end else if (stall_any) begin
      st_d    = S_BLOCK;
      inc_blk = 1'b1;
    end else if (st_q == S_BLOCK) begin
      inc_blk = 1'b1;
      if (!hold_q) st_d = S_RUN;
    end else if (st_q == S_MWAIT) begin
      if (ic_done) st_d = S_MFILL;
    end else begin
      fetch_en = 1'b1;
      inc_run  = 1'b1;
      if (fetch_fault) begin
        st_d   = S_BLOCK;
        hold_d = 1'b1;
      end else if (ic_miss && st_q != S_MFILL) begin
        st_d = S_MWAIT;
      end else begin
        st_d = S_RUN;
        pc_d = dp_next_pc;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= S_IDLE;
      pc_q        <= RESET_PC;
      hold_q      <= 1'b0;
      run_cnt     <= '0;
      squash_cnt  <= '0;
      blocked_cnt <= '0;
    end else begin
      st_q   <= st_d;
      pc_q   <= pc_d;
      hold_q <= hold_d;
      if (inc_run && run_cnt != CMAX)        run_cnt     <= run_cnt + 1'b1;
      if (inc_sq && squash_cnt != CMAX)      squash_cnt  <= squash_cnt + 1'b1;
      if (inc_blk && blocked_cnt != CMAX)    blocked_cnt <= blocked_cnt + 1'b1;
    end
  end

  assign state   = st_q;
  assign pc      = pc_q;
  assign next_pc = pc_q + STEP;

endmodule

// File: rtl/fetch_ctl_chk.sv
module fetch_ctl_chk #(
  parameter int PCW  = 32,
  parameter int CNTW = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmt_squash,
  input logic            cmt_rob_busy,
  input logic [PCW-1:0]  cmt_target,
  input logic            dec_squash,
  input logic            dec_stall,
  input logic            ren_stall,
  input logic            exe_stall,
  input logic            cmt_stall,
  input logic            fetch_en,
  input logic [2:0]      state,
  input logic [PCW-1:0]  pc,
  input logic            ic_cancel,
  input logic [CNTW-1:0] run_cnt,
  input logic [CNTW-1:0] squash_cnt,
  input logic [CNTW-1:0] blocked_cnt
);

  logic stall_any;
  assign stall_any = dec_stall | ren_stall | exe_stall | cmt_stall;

  assert_commit_redirect_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_squash |=> (state == 3'd2 && pc == $past(cmt_target)));

  assert_commit_no_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_squash |-> !fetch_en);

  assert_drain_no_fetch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmt_squash && cmt_rob_busy) |-> !fetch_en);

  assert_stall_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmt_squash && !cmt_rob_busy && !(dec_squash && state != 3'd2) && stall_any)
      |=> state == 3'd3);

  assert_misswait_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    state == 3'd4 |-> !fetch_en);

  assert_cancel_in_miss_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ic_cancel |-> state == 3'd4);

  assert_counters_monotone_R13: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (run_cnt >= $past(run_cnt) && squash_cnt >= $past(squash_cnt)
              && blocked_cnt >= $past(blocked_cnt)));

endmodule

bind fetch_ctl fetch_ctl_chk #(.PCW(PCW), .CNTW(CNTW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmt_squash(cmt_squash), .cmt_rob_busy(cmt_rob_busy),
  .cmt_target(cmt_target), .dec_squash(dec_squash), .dec_stall(dec_stall),
  .ren_stall(ren_stall), .exe_stall(exe_stall), .cmt_stall(cmt_stall),
  .fetch_en(fetch_en), .state(state), .pc(pc), .ic_cancel(ic_cancel),
  .run_cnt(run_cnt), .squash_cnt(squash_cnt), .blocked_cnt(blocked_cnt)
);

// File: tb/tb_fetch_ctl.sv
`timescale 1ns/1ps
module tb_fetch_ctl;
  localparam int PCW = 32, SEQW = 16, CW = 4, IB = 4;
  localparam logic [PCW-1:0] RPC = 32'h0000_1000;

  logic clk = 0, rst_n = 0;
  logic cmt_squash, cmt_mispred, cmt_taken, cmt_rob_busy, cmt_stall;
  logic [PCW-1:0] cmt_target, dec_target, dp_next_pc;
  logic [SEQW-1:0] cmt_seq, dec_seq;
  logic dec_squash, dec_mispred, dec_taken, dec_stall, ren_stall, exe_stall;
  logic ic_miss, ic_done, fetch_fault;
  logic fetch_en, fix_valid, fix_mispred, fix_taken, upd_valid, ic_cancel;
  logic [2:0] state;
  logic [PCW-1:0] pc, next_pc, fix_target;
  logic [SEQW-1:0] fix_seq, upd_seq;
  logic [CW-1:0] run_cnt, squash_cnt, blocked_cnt;

  fetch_ctl #(.PCW(PCW), .SEQW(SEQW), .CNTW(CW), .INST_BYTES(IB), .RESET_PC(RPC)) dut (.*);

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // reference state
  logic [2:0] m_st; logic [PCW-1:0] m_pc; logic m_hold;
  logic [CW-1:0] m_run, m_sq, m_blk;
  logic e_fetch, e_fix, e_fixm, e_fixt, e_upd, e_cancel;
  logic [SEQW-1:0] e_fseq; logic [PCW-1:0] e_ftgt;
  logic c_fetch, c_fix, c_cancel, c_upd;

  function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] v, input bit en);
    return (en && v != '1) ? v + 1'b1 : v;
  endfunction

  task automatic model_reset();
    m_st = 0; m_pc = RPC; m_hold = 0; m_run = 0; m_sq = 0; m_blk = 0;
  endtask

  task automatic model_step();
    logic [2:0] nst; logic [PCW-1:0] npc; logic nh; bit ir, is, ib, stl, dred;
    nst = m_st; npc = m_pc; nh = m_hold; ir = 0; is = 0; ib = 0;
    stl = dec_stall | ren_stall | exe_stall | cmt_stall;
    dred = !cmt_squash && !cmt_rob_busy && dec_squash && m_st != 2;
    e_fetch = 0; e_fix = 0; e_fixm = 0; e_fixt = 0; e_fseq = 0; e_ftgt = 0;
    e_upd = !cmt_squash && cmt_seq != 0;
    e_cancel = (cmt_squash || dred) && m_st == 4;
    if (cmt_squash) begin
      e_fix = 1; e_fixm = cmt_mispred; e_fixt = cmt_taken; e_fseq = cmt_seq; e_ftgt = cmt_target;
      npc = cmt_target; nst = 2; nh = 0; is = 1;
    end else if (cmt_rob_busy) begin
      nst = 2; nh = 0; is = 1;
    end else begin
      if (dec_squash) begin
        e_fix = 1; e_fixm = dec_mispred; e_fixt = dec_taken; e_fseq = dec_seq; e_ftgt = dec_target;
      end
      if (dred) begin npc = dec_target; nst = 2; nh = 0; is = 1; end
      else if (stl) begin nst = 3; ib = 1; end
      else if (m_st == 3) begin ib = 1; if (!m_hold) nst = 1; end
      else if (m_st == 4) begin if (ic_done) nst = 5; end
      else begin
        e_fetch = 1; ir = 1;
        if (fetch_fault) begin nst = 3; nh = 1; end
        else if (ic_miss && m_st != 5) nst = 4;
        else begin nst = 1; npc = dp_next_pc; end
      end
    end
    check(fetch_en == e_fetch, "R9 fetch_en", fetch_en, e_fetch);
    check(fix_valid == e_fix, "R3 fix_valid", fix_valid, e_fix);
    if (e_fix)
      check(fix_mispred == e_fixm && fix_taken == e_fixt && fix_seq == e_fseq && fix_target == e_ftgt,
            "R3 fix fields", {fix_mispred, fix_taken, fix_seq, fix_target},
            {e_fixm, e_fixt, e_fseq, e_ftgt});
    check(upd_valid == e_upd && (!e_upd || upd_seq == cmt_seq), "R4 update", upd_valid, e_upd);
    check(ic_cancel == e_cancel, "R11 ic_cancel", ic_cancel, e_cancel);
    c_fetch = fetch_en; c_fix = fix_valid; c_cancel = ic_cancel; c_upd = upd_valid;
    m_st = nst; m_pc = npc; m_hold = nh;
    m_run = sat_inc(m_run, ir); m_sq = sat_inc(m_sq, is); m_blk = sat_inc(m_blk, ib);
  endtask

  task automatic quiet();
    cmt_squash = 0; cmt_mispred = 0; cmt_taken = 0; cmt_target = 0; cmt_seq = 0;
    cmt_rob_busy = 0; cmt_stall = 0; dec_squash = 0; dec_mispred = 0; dec_taken = 0;
    dec_target = 0; dec_seq = 0; dec_stall = 0; ren_stall = 0; exe_stall = 0;
    ic_miss = 0; ic_done = 0; fetch_fault = 0; dp_next_pc = 32'h2000;
  endtask

  // inputs are set at a negedge; evaluate, clock, then compare registered state
  task automatic cycle();
    #1;
    model_step();
    @(negedge clk);
    check(state == m_st, "R6 state", state, m_st);
    check(pc == m_pc && next_pc == m_pc + IB, "R14 pc", pc, m_pc);
    check(run_cnt == m_run && squash_cnt == m_sq && blocked_cnt == m_blk, "R13 counters",
          {run_cnt, squash_cnt, blocked_cnt}, {m_run, m_sq, m_blk});
  endtask

  initial begin
    #100000;
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    quiet();
    repeat (3) @(negedge clk);
    rst_n = 1; model_reset();
    check(state == 0 && pc == RPC && next_pc == RPC + IB, "R1 reset state/pc", pc, RPC);
    check(run_cnt == 0 && squash_cnt == 0 && blocked_cnt == 0, "R1 reset counters", run_cnt, 0);

    // R7 / R13: long stall saturates the blocked counter
    ren_stall = 1;
    for (int i = 0; i < 20; i++) cycle();
    check(state == 3, "R7 stall blocks", state, 3);
    check(blocked_cnt == '1, "R13 saturation", blocked_cnt, 15);
    // R8: unblock cycle idle
    quiet(); cycle();
    check(c_fetch == 0 && state == 1, "R8 unblock idle", {c_fetch, state}, 1);
    // R14: fetch advances pc
    dp_next_pc = 32'h3330; cycle();
    check(pc == 32'h3330 && next_pc == 32'h3334, "R14 fetch advance", pc, 32'h3330);
    // R10: miss, fill, refetch ignoring miss
    ic_miss = 1; cycle();
    check(state == 4 && pc == 32'h3330, "R10 miss wait", state, 4);
    ic_miss = 0; cycle();
    check(state == 4 && c_fetch == 0, "R10 wait holds", state, 4);
    ic_done = 1; cycle();
    check(state == 5, "R10 filled", state, 5);
    ic_done = 0; ic_miss = 1; dp_next_pc = 32'h3340; cycle();
    check(c_fetch == 1 && state == 1 && pc == 32'h3340, "R10 filled ignores miss", state, 1);
    // R11 / R2: commit squash during miss wait
    cycle();
    check(state == 4, "R10 second miss", state, 4);
    ic_miss = 0; cmt_squash = 1; cmt_target = 32'h8000; cmt_mispred = 1; cmt_seq = 16'h55;
    dec_squash = 1; dec_target = 32'h9000; ren_stall = 1; cycle();
    check(c_cancel == 1, "R11 cancel on redirect", c_cancel, 1);
    check(state == 2 && pc == 32'h8000 && c_fetch == 0, "R2 commit priority", pc, 32'h8000);
    // R5: drain beats decode squash and stall
    quiet(); cmt_rob_busy = 1; dec_squash = 1; dec_target = 32'h9000; exe_stall = 1; cycle();
    check(state == 2 && c_fix == 0 && c_fetch == 0, "R5 drain", {state, c_fix}, 4);
    // R6: decode squash while squashing does not redirect; R9 exit fetches
    quiet(); dec_squash = 1; dec_target = 32'h9000; dp_next_pc = 32'h8010; cycle();
    check(c_fix == 1 && c_fetch == 1 && pc == 32'h8010, "R9 squash exit fetch / R6 no redirect", pc, 32'h8010);
    dec_target = 32'h9100; cycle();
    check(state == 2 && pc == 32'h9100, "R6 decode redirect", pc, 32'h9100);
    // R12: fault holds blocked until redirect
    quiet(); fetch_fault = 1; cycle();
    check(state == 3, "R12 fault blocks", state, 3);
    fetch_fault = 0;
    for (int i = 0; i < 3; i++) cycle();
    check(state == 3, "R12 fault held", state, 3);
    dec_squash = 1; dec_target = 32'hA000; cycle();
    check(state == 2 && pc == 32'hA000, "R12 release by redirect", pc, 32'hA000);
    // R4: plain update
    quiet(); cmt_seq = 16'h77; cycle();
    check(c_upd == 1, "R4 update issued", c_upd, 1);

    // random phase
    for (int n = 0; n < 3000; n++) begin
      cmt_squash   = ($urandom % 100) < 4;
      cmt_mispred  = $urandom % 2;
      cmt_taken    = $urandom % 2;
      cmt_target   = $urandom & 32'hFFFC;
      cmt_seq      = ($urandom % 2) ? 16'($urandom) : 16'h0;
      cmt_rob_busy = ($urandom % 100) < 5;
      cmt_stall    = ($urandom % 100) < 4;
      dec_squash   = ($urandom % 100) < 7;
      dec_mispred  = $urandom % 2;
      dec_taken    = $urandom % 2;
      dec_target   = $urandom & 32'hFFFC;
      dec_seq      = 16'($urandom);
      dec_stall    = ($urandom % 100) < 4;
      ren_stall    = ($urandom % 100) < 4;
      exe_stall    = ($urandom % 100) < 4;
      ic_miss      = ($urandom % 100) < 25;
      ic_done      = ($urandom % 100) < 30;
      fetch_fault  = ($urandom % 100) < 3;
      dp_next_pc   = $urandom & 32'hFFFC;
      cycle();
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule